// File: doc/BRIEF.md
# External-Master Burst Chip-Select Responder

This block lives inside a processor that normally owns the memory bus. It serves the case where a foreign bus master has taken the bus. The foreign master drives an address, a read/write line, a transfer-start strobe, a transfer-in-progress strobe, a transfer type and a size code. The block samples these once, at the rising clock edge where the start strobe is seen. It matches the address against a fixed set of chip-select windows and then works as the slave-side strobe generator for the whole access.

After the capture, the block drives one chip select and the byte-lane enables to the selected memory. These strobes change on the falling clock edge. The block paces each data beat with a transfer-acknowledge pulse, which changes on the rising edge. A line-sized access becomes a four-beat burst. Every window adds its own fixed number of wait cycles before each acknowledge. While the foreign master holds the bus, the processor's own bus-request and bus-driven outputs are forced inactive.

Top module: `xm_burst_responder`

## Requirements
- R1: An access is accepted on a rising clock edge only when all of the following hold: the block is idle, start is low, transfer-in-progress is low, hold-request is high, the transfer type is 00, and the address hits a window. From that edge until the block is idle again, changes on address, direction and size have no effect.
- R2: Window i matches when `((addr ^ base_i) & mask_i) == 0`. When several windows match, the lowest index wins. The selected window drives `cs_n_o[i]` low, and at most one chip select is low at any time.
- R3: An address that hits no window produces no chip select, no byte enable and no acknowledge.
- R4: Chip select and byte enables go low on the falling clock edge that follows the capture edge.
- R5: Byte enables use size codes 00 longword, 01 byte, 10 word and 11 line. `be_n_o[k]` is the lane of byte offset k, taken from address bits [1:0]. Longword and line enable all four lanes. A word enables lanes 1:0 when address bit 1 is 0, and lanes 3:2 otherwise. A byte enables only lane `addr[1:0]`.
- R6: Size 11 gives four acknowledge beats. Every other size gives one beat.
- R7: For a window with wait count w (0 to 3), the acknowledge of beat k (counting from 0) goes low for exactly one cycle. It does so on rising edge (k+1)(w+1) after the capture edge.
- R8: Chip select and byte enables stay low through the cycle of the last acknowledge. They go high on the falling edge of the next cycle, and the acknowledge is then high.
- R9: A start strobe seen while a burst is running, or in the cycle right after it, is ignored.
- R10: While hold-request is high, `br_n_o` and `bd_n_o` are high. Otherwise each is the inverse of the processor's own request and drive inputs.
- R11: A start with a transfer type other than 00, with transfer-in-progress high, or with hold-request low produces no strobes.
- R12: `rd_o` takes the read/write level captured at the accept edge and holds it for the whole burst.
- R13: During reset, all chip selects, byte enables and the acknowledge are high, and `rd_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock. Both edges are used. |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_req_i | input | 1 | Foreign master owns the bus |
| cpu_br_i | input | 1 | Processor's own bus request, active high |
| cpu_bd_i | input | 1 | Processor's own bus-driven indication, active high |
| ts_n_i | input | 1 | Transfer start from the foreign master, active low |
| tip_n_i | input | 1 | Transfer in progress, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| ttype_i | input | 2 | Transfer type; only 00 is served |
| size_i | input | 2 | Size code (see R5) |
| addr_i | input | AW | Address from the foreign master |
| cs_n_o | output | NWIN | Chip selects, active low, one per window |
| be_n_o | output | 4 | Byte-lane enables, active low |
| ta_n_o | output | 1 | Transfer acknowledge, active low |
| rd_o | output | 1 | Captured direction for the device |
| br_n_o | output | 1 | Bus request out, active low |
| bd_n_o | output | 1 | Bus driven out, active low |

## Verification
The bench uses the default parameters: four windows with wait counts 0, 1, 2 and 3. This means every wait setting can be reached, both for single beats and for four-beat line bursts. Window 3 covers window 2's small region, so one address matches both windows. The two windows have different wait counts, so the acknowledge timing shows which window won the priority. Addresses above both windows provide misses.

// File: rtl/xmb_pkg.sv
// Package: shared constants and types for the external-master burst responder.
// Assumes a 32-bit data port with four byte lanes.
package xmb_pkg;

    localparam int LANES      = 4;
    localparam int OFF_W      = $clog2(LANES);
    localparam int LINE_BEATS = 4;
    localparam int BEAT_W     = $clog2(LINE_BEATS);

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LINE = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'b00,
        SEQ_RUN  = 2'b01,
        SEQ_TAIL = 2'b10
    } seq_state_e;

endpackage

// File: rtl/xmb_win_decode.sv
// Module: xmb_win_decode
// Matches an address against NWIN base/mask windows. Returns a one-hot
// selection with the lowest index taking priority, plus that window's wait count.
// Assumes: a mask bit set to 1 means the address bit is compared.
module xmb_win_decode #(
    parameter int AW   = 32,
    parameter int NWIN = 4,
    parameter int WW   = 2,
    parameter logic [NWIN*AW-1:0] BASE = '0,
    parameter logic [NWIN*AW-1:0] MASK = '0,
    parameter logic [NWIN*WW-1:0] WAIT = '0
) (
    input  logic [AW-1:0]   addr_i,
    output logic            hit_o,
    output logic [NWIN-1:0] sel_o,
    output logic [WW-1:0]   wait_o
);

    logic [NWIN-1:0] match;

    // One comparator per window.
    for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
        assign match[gi] = ((addr_i ^ BASE[gi*AW +: AW]) & MASK[gi*AW +: AW]) == '0;
    end

    // Priority pick: scan high to low so the lowest matching index wins.
    always_comb begin
        sel_o  = '0;
        wait_o = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel_o    = '0;
                sel_o[i] = 1'b1;
                wait_o   = WAIT[i*WW +: WW];
            end
        end
        hit_o = |match;
    end

endmodule

// File: rtl/xmb_lane_gen.sv
// Module: xmb_lane_gen
// Turns a size code and the low address bits into active-high byte-lane
// enables and the index of the last beat.
// Assumes: four lanes, where bit k is byte offset k.
module xmb_lane_gen
    import xmb_pkg::*;
(
    input  logic [1:0]        size_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [LANES-1:0]  be_o,
    output logic [BEAT_W-1:0] last_idx_o
);

    // Lane and burst-length selection from the size code.
    always_comb begin
        unique case (xfer_size_e'(size_i))
            SZ_BYTE: be_o = LANES'(1) << off_i;
            SZ_WORD: be_o = off_i[1] ? 4'b1100 : 4'b0011;
            default: be_o = '1;
        endcase
        last_idx_o = (xfer_size_e'(size_i) == SZ_LINE) ? BEAT_W'(LINE_BEATS - 1) : '0;
    end

endmodule

// File: rtl/xmb_beat_seq.sv
// Module: xmb_beat_seq
// Rising-edge sequencer that paces the acknowledge pulses. It loads the wait
// count and the last-beat index on start. Each beat waits that many cycles
// and then gives a one-cycle low acknowledge. After the last beat it spends
// one tail cycle before going idle.
// Assumes: start_i is only raised while busy_o is low.
module xmb_beat_seq
    import xmb_pkg::*;
#(
    parameter int WW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WW-1:0]     wait_i,
    input  logic [BEAT_W-1:0] last_idx_i,
    output logic              ta_n_o,
    output logic              busy_o
);

    seq_state_e        st;
    logic [WW-1:0]     wcnt;
    logic [WW-1:0]     wload;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] last_idx;

    // Beat sequencing and acknowledge generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SEQ_IDLE;
            ta_n_o   <= 1'b1;
            wcnt     <= '0;
            wload    <= '0;
            beat     <= '0;
            last_idx <= '0;
        end else begin
            unique case (st)
                SEQ_IDLE: begin
                    ta_n_o <= 1'b1;
                    if (start_i) begin
                        st       <= SEQ_RUN;
                        wcnt     <= wait_i;
                        wload    <= wait_i;
                        beat     <= '0;
                        last_idx <= last_idx_i;
                    end
                end
                SEQ_RUN: begin
                    if (wcnt == '0) begin
                        ta_n_o <= 1'b0;
                        wcnt   <= wload;
                        beat   <= beat + BEAT_W'(1);
                        if (beat == last_idx) begin
                            st <= SEQ_TAIL;
                        end
                    end else begin
                        ta_n_o <= 1'b1;
                        wcnt   <= wcnt - WW'(1);
                    end
                end
                default: begin
                    ta_n_o <= 1'b1;
                    st     <= SEQ_IDLE;
                end
            endcase
        end
    end

    assign busy_o = (st != SEQ_IDLE);

endmodule

// File: rtl/xmb_strobe_drv.sv
// Module: xmb_strobe_drv
// Falling-edge output stage for the chip selects and byte enables. It shows
// the captured selection while the sequencer is busy and all-high otherwise.
// Assumes: busy_i and the selection come from rising-edge registers.
module xmb_strobe_drv
    import xmb_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic [NWIN-1:0]  sel_i,
    input  logic [LANES-1:0] be_i,
    output logic [NWIN-1:0]  cs_n_o,
    output logic [LANES-1:0] be_n_o
);

    // Half-cycle-offset strobe registers.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            cs_n_o <= '1;
            be_n_o <= '1;
        end else if (busy_i) begin
            cs_n_o <= ~sel_i;
            be_n_o <= ~be_i;
        end else begin
            cs_n_o <= '1;
            be_n_o <= '1;
        end
    end

endmodule

// File: rtl/xm_burst_responder.sv
// Module: xm_burst_responder (top)
// Serves a transfer started by a foreign bus master. It samples the request
// once at the start edge, decodes the chip-select window, drives the strobes
// on the falling edge and paces the acknowledges on the rising edge. It also
// masks the processor's own bus request and bus-driven outputs while the
// bus is held.
// Assumes: a 32-bit device port; window layout fixed by parameters.
module xm_burst_responder
    import xmb_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NWIN = 4,
    parameter int WW   = 2,
    parameter logic [NWIN*AW-1:0] WIN_BASE = {32'h2000_0000, 32'h2000_0000,
                                              32'h1000_0000, 32'h0000_0000},
    parameter logic [NWIN*AW-1:0] WIN_MASK = {32'hF000_0000, 32'hFFFF_F000,
                                              32'hFFF0_0000, 32'hFFF0_0000},
    parameter logic [NWIN*WW-1:0] WIN_WAIT = {2'd3, 2'd2, 2'd1, 2'd0}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_req_i,
    input  logic             cpu_br_i,
    input  logic             cpu_bd_i,
    input  logic             ts_n_i,
    input  logic             tip_n_i,
    input  logic             rw_i,
    input  logic [1:0]       ttype_i,
    input  logic [1:0]       size_i,
    input  logic [AW-1:0]    addr_i,
    output logic [NWIN-1:0]  cs_n_o,
    output logic [LANES-1:0] be_n_o,
    output logic             ta_n_o,
    output logic             rd_o,
    output logic             br_n_o,
    output logic             bd_n_o
);

    logic              hit;
    logic [NWIN-1:0]   sel_d;
    logic [WW-1:0]     wait_d;
    logic [LANES-1:0]  be_d;
    logic [BEAT_W-1:0] last_idx_d;
    logic              busy;
    logic              start;
    logic [NWIN-1:0]   sel_q;
    logic [LANES-1:0]  be_q;

    xmb_win_decode #(
        .AW(AW), .NWIN(NWIN), .WW(WW),
        .BASE(WIN_BASE), .MASK(WIN_MASK), .WAIT(WIN_WAIT)
    ) u_dec (
        .addr_i (addr_i),
        .hit_o  (hit),
        .sel_o  (sel_d),
        .wait_o (wait_d)
    );

    xmb_lane_gen u_lane (
        .size_i     (size_i),
        .off_i      (addr_i[OFF_W-1:0]),
        .be_o       (be_d),
        .last_idx_o (last_idx_d)
    );

    // Accept condition for a new access.
    always_comb begin
        start = !busy && !ts_n_i && !tip_n_i && hold_req_i &&
                (ttype_i == 2'b00) && hit;
    end

    // Capture of selection, lanes and direction at the accept edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            be_q  <= '0;
            rd_o  <= 1'b0;
        end else if (start) begin
            sel_q <= sel_d;
            be_q  <= be_d;
            rd_o  <= rw_i;
        end
    end

    xmb_beat_seq #(.WW(WW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .wait_i     (wait_d),
        .last_idx_i (last_idx_d),
        .ta_n_o     (ta_n_o),
        .busy_o     (busy)
    );

    xmb_strobe_drv #(.NWIN(NWIN)) u_drv (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (busy),
        .sel_i  (sel_q),
        .be_i   (be_q),
        .cs_n_o (cs_n_o),
        .be_n_o (be_n_o)
    );

    // Own-bus outputs are suppressed while the foreign master holds the bus.
    assign br_n_o = !(cpu_br_i && !hold_req_i);
    assign bd_n_o = !(cpu_bd_i && !hold_req_i);

endmodule

// File: rtl/xmb_chk.sv
// Module: xmb_chk
// Checker bound to xm_burst_responder. It watches the relations between the
// strobe outputs and the acknowledge over time.
module xmb_chk #(
    parameter int NWIN = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hold_req_i,
    input logic [NWIN-1:0] cs_n_o,
    input logic [3:0]      be_n_o,
    input logic            ta_n_o,
    input logic            rd_o,
    input logic            br_n_o,
    input logic            bd_n_o
);

    // R2
    one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    // R3
    ta_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ta_n_o |-> (cs_n_o != '1));

    // R8
    be_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_o == '1) |-> (be_n_o == '1));

    // R9
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cs_n_o != '1) && $past(cs_n_o != '1)) |-> $stable(cs_n_o));

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cs_n_o != '1) && $past(cs_n_o != '1)) |-> $stable(rd_o));

    // R10
    hold_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req_i |-> (br_n_o && bd_n_o));

endmodule

bind xm_burst_responder xmb_chk #(.NWIN(NWIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_req_i (hold_req_i),
    .cs_n_o     (cs_n_o),
    .be_n_o     (be_n_o),
    .ta_n_o     (ta_n_o),
    .rd_o       (rd_o),
    .br_n_o     (br_n_o),
    .bd_n_o     (bd_n_o)
);

// File: tb/tb_xm_burst_responder.sv
// Bench for xm_burst_responder: directed corner cases plus seeded random
// accesses, compared against a model built from the requirements.
module tb_xm_burst_responder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hold_req_i, cpu_br_i, cpu_bd_i, ts_n_i, tip_n_i, rw_i;
    logic [1:0]  ttype_i, size_i;
    logic [31:0] addr_i;
    logic [3:0]  cs_n_o, be_n_o;
    logic        ta_n_o, rd_o, br_n_o, bd_n_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xm_burst_responder dut (
        .clk(clk), .rst_n(rst_n), .hold_req_i(hold_req_i), .cpu_br_i(cpu_br_i),
        .cpu_bd_i(cpu_bd_i), .ts_n_i(ts_n_i), .tip_n_i(tip_n_i), .rw_i(rw_i),
        .ttype_i(ttype_i), .size_i(size_i), .addr_i(addr_i), .cs_n_o(cs_n_o),
        .be_n_o(be_n_o), .ta_n_o(ta_n_o), .rd_o(rd_o), .br_n_o(br_n_o),
        .bd_n_o(bd_n_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Window model (R2): lowest matching index wins, -1 for a miss.
    function automatic int exp_win(input logic [31:0] a);
        if ((a & 32'hFFF0_0000) == 32'h0000_0000) return 0;
        if ((a & 32'hFFF0_0000) == 32'h1000_0000) return 1;
        if ((a & 32'hFFFF_F000) == 32'h2000_0000) return 2;
        if ((a & 32'hF000_0000) == 32'h2000_0000) return 3;
        return -1;
    endfunction

    // Lane model (R5), active high.
    function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] off);
        case (sz)
            2'b01:   return 4'b0001 << off;
            2'b10:   return off[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // One access from the start strobe to idle, checked every cycle.
    task automatic xfer(input logic [31:0] a, input logic [1:0] sz, input logic rw,
                        input logic [1:0] tt, input logic hold, input logic tip_n,
                        input bit mid_ts, input string tag);
        int win, w, n, last, ns;
        bit acc, act;
        logic [3:0] ecs, ebe;
        logic eta;
        win  = exp_win(a);
        acc  = hold && !tip_n && (tt == 2'b00) && (win >= 0);
        w    = acc ? win : 0;              // default waits equal the window index
        n    = (sz == 2'b11) ? 4 : 1;
        last = n * (w + 1);
        ns   = acc ? last + 3 : 6;
        hold_req_i = hold; ts_n_i = 1'b0; tip_n_i = tip_n;
        addr_i = a; size_i = sz; rw_i = rw; ttype_i = tt;
        @(posedge clk); #1;
        // R1: scramble the sampled inputs after the accept edge
        ts_n_i = 1'b1; addr_i = $urandom; rw_i = ~rw; size_i = 2'($urandom);
        for (int j = 0; j < ns; j++) begin
            #6;
            act = acc && (j <= last);
            ecs = act ? ~(4'b0001 << win) : 4'hF;
            ebe = act ? ~exp_be(sz, a[1:0]) : 4'hF;
            eta = !(acc && j >= 1 && j <= last && (j % (w + 1)) == 0);
            check(cs_n_o === ecs, {tag, " R2 R4 R8 cs"}, cs_n_o, ecs);
            check(be_n_o === ebe, {tag, " R5 be"}, be_n_o, ebe);
            check(ta_n_o === eta, {tag, " R6 R7 ta"}, ta_n_o, eta);
            if (act) check(rd_o === rw, {tag, " R12 rd"}, rd_o, rw);
            @(posedge clk); #1;
            if (mid_ts && j == 0) begin
                // R9: a new start while the burst runs
                ts_n_i = 1'b0; addr_i = 32'h1000_0040; ttype_i = 2'b00; size_i = 2'b01;
            end else begin
                ts_n_i = 1'b1;
            end
        end
        ts_n_i = 1'b1; tip_n_i = 1'b1; hold_req_i = 1'b1; ttype_i = 2'b00;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        void'($urandom(32'd7321));
        rst_n = 1'b0; hold_req_i = 1'b1; cpu_br_i = 1'b0; cpu_bd_i = 1'b0;
        ts_n_i = 1'b1; tip_n_i = 1'b1; rw_i = 1'b0; ttype_i = 2'b00;
        size_i = 2'b00; addr_i = '0;
        repeat (4) @(posedge clk);
        #7;
        // R13: reset state
        check(cs_n_o === 4'hF, "R13 cs", cs_n_o, 32'hF);
        check(be_n_o === 4'hF, "R13 be", be_n_o, 32'hF);
        check(ta_n_o === 1'b1, "R13 ta", ta_n_o, 1);
        check(rd_o === 1'b0, "R13 rd", rd_o, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R10: own-bus outputs masked while held
        cpu_br_i = 1'b1; cpu_bd_i = 1'b1; hold_req_i = 1'b1; #1;
        check(br_n_o === 1'b1, "R10 br held", br_n_o, 1);
        check(bd_n_o === 1'b1, "R10 bd held", bd_n_o, 1);
        hold_req_i = 1'b0; #1;
        check(br_n_o === 1'b0, "R10 br free", br_n_o, 0);
        check(bd_n_o === 1'b0, "R10 bd free", bd_n_o, 0);
        cpu_br_i = 1'b0; #1;
        check(br_n_o === 1'b1, "R10 br idle", br_n_o, 1);
        cpu_bd_i = 1'b0; hold_req_i = 1'b1;
        @(posedge clk); #1;

        // Directed corner cases
        xfer(32'h0000_0100, 2'b11, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, "R6 line w0");
        xfer(32'h1000_0008, 2'b11, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, "R7 line w1");
        for (int k = 0; k < 4; k++)
            xfer(32'h2000_0020 + 32'(k), 2'b01, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, "R5 byte");
        xfer(32'h2100_0002, 2'b10, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, "R5 word hi w3");
        xfer(32'h2100_0000, 2'b10, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, "R5 word lo");
        xfer(32'h2000_0010, 2'b11, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, "R2 priority");
        xfer(32'h5000_0000, 2'b11, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, "R3 miss");
        xfer(32'h1000_0000, 2'b00, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, "R11 no hold");
        xfer(32'h1000_0000, 2'b00, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, "R11 ttype");
        xfer(32'h1000_0000, 2'b00, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, "R11 tip high");
        xfer(32'h0000_0004, 2'b00, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, "R9 ts in single");
        xfer(32'h2300_0000, 2'b11, 1'b1, 2'b00, 1'b1, 1'b0, 1'b1, "R9 ts in burst");
        xfer(32'h0000_0000, 2'b00, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, "R1 back to back");

        // Seeded random accesses
        for (int it = 0; it < 60; it++) begin
            logic [1:0] tt;
            case ($urandom_range(0, 4))
                0:       a = $urandom & 32'h000F_FFFF;
                1:       a = 32'h1000_0000 | ($urandom & 32'h000F_FFFF);
                2:       a = 32'h2000_0000 | ($urandom & 32'h0000_0FFF);
                3:       a = 32'h2000_0000 | ($urandom & 32'h0FFF_FFFF);
                default: a = 32'h6000_0000 | ($urandom & 32'h0FFF_FFFF);
            endcase
            tt = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            xfer(a, 2'($urandom), 1'($urandom), tt, ($urandom_range(0, 7) != 0),
                 ($urandom_range(0, 7) == 0), 1'b0, "R1 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule